// File: doc/BRIEF.md
# Stereo Soft Mute with Zero-Run Automute

This block sits on a stereo PCM sample stream between the serial receiver and the interpolation filter. Each accepted sample pair is multiplied by a shared gain that walks one step per sample period. The gain drifts towards silence when a mute is requested and back towards unity when the request goes away. Muting therefore fades the signal out and in, with no hard cut.

A two-bit mode input chooses how the mute request is formed. In pass mode the request is always off, and zero detection is disabled. In forced mode the request is always on. In automatic mode the request comes from a zero-run detector. That detector raises a status flag once enough back-to-back sample pairs arrive with both channels at zero. It drops the flag on the first pair in which either channel is non-zero.

Top module: `pcm_softmute`

## Requirements
- R1: With `mute_mode` = 2'b00 (pass), `automute` stays 0 however many zero samples arrive, and the gain climbs one step per sample until it reaches unity.
- R2: With `mute_mode` = 2'b01 (forced), and also with the reserved code 2'b11, the gain falls one step per sample down to 0. After that, every output sample is exactly zero.
- R3: With `mute_mode` = 2'b10 (automatic), `automute` rises in the cycle after the 1024th consecutive accepted pair with both channels zero, and not before.
- R4: In automatic mode, `automute` is 0 in the cycle after an accepted pair in which either channel is non-zero, and the zero run starts again from that point.
- R5: In automatic mode, the gain falls while `automute` is 1 and rises while it is 0, using the flag value from before the current sample.
- R6: The gain is a 10-bit value in the range 0 to 1023. It resets to 1023, changes only on cycles with `in_valid`, and moves by at most one per accepted sample.
- R7: Each output sample is computed from the gain held before that sample's step. At gain 1023 the output equals the input. Below 1023 it is floor(input × gain / 1024), computed on signed two's-complement values and truncated to 24 bits. At gain 0 it is zero.
- R8: `out_valid` is high exactly one cycle after each `in_valid`. Between accepted samples, the output data holds its last value.
- R9: Any cycle with the mode set to something other than automatic clears the zero run and the flag, so a new flag needs a full new run of 1024.
- R10: After reset, `out_valid`, `out_left`, `out_right` and `automute` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mute_mode | input | 2 | 00 pass, 01 forced mute, 10 automatic, 11 treated as forced |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| out_valid | output | 1 | Scaled pair strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| automute | output | 1 | Zero-run flag |

## Verification
The scaler is driven with full-scale positive and negative values, with minus one, and with values that differ between the two channels. Using different left and right values exposes a swapped or shared channel. Minus one at half gain separates arithmetic flooring from logical shifting or rounding.

The zero detector receives runs of 1023 and of 1024 zero pairs to pin down the exact threshold. A single non-zero pair then tests the clear. Zero runs in pass mode, and a run broken by a mode change, show that the count is neither kept nor started outside automatic mode. Complete fades down and back up show the step size and both end stops.

// File: rtl/pcm_softmute_pkg.sv
package pcm_softmute_pkg;

   typedef enum logic [1:0] {
      MUTE_MODE_PASS  = 2'b00,
      MUTE_MODE_FORCE = 2'b01,
      MUTE_MODE_AUTO  = 2'b10,
      MUTE_MODE_RSVD  = 2'b11
   } mute_mode_e;

   // Forced mute covers the reserved code as well, so an undriven or
   // corrupted control always fails towards silence.
   function automatic logic mode_forces_mute(input logic [1:0] m);
      return (m == MUTE_MODE_FORCE) || (m == MUTE_MODE_RSVD);
   endfunction

   function automatic logic mode_is_auto(input logic [1:0] m);
      return m == MUTE_MODE_AUTO;
   endfunction

endpackage

// File: rtl/pcm_zero_watch.sv
// Counts back-to-back all-zero sample pairs and flags a full run.
module pcm_zero_watch #(
   parameter int DATA_W  = 24,
   parameter int RUN_LEN = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              watch_en,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_left,
   input  logic [DATA_W-1:0] smp_right,
   output logic              run_flag
);

   localparam int CNT_W = $clog2(RUN_LEN + 1);
   localparam logic [CNT_W-1:0] RUN_CNT = CNT_W'(RUN_LEN);

   logic [CNT_W-1:0] run_cnt;
   logic             pair_zero;

   assign pair_zero = (smp_left == '0) && (smp_right == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (!watch_en) begin
         run_cnt <= '0;
      end else if (smp_valid) begin
         if (!pair_zero) begin
            run_cnt <= '0;
         end else if (run_cnt != RUN_CNT) begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   assign run_flag = (run_cnt == RUN_CNT);

endmodule

// File: rtl/pcm_gain_ramp.sv
// Shared fade gain: one step per accepted sample towards 0 or full scale.
module pcm_gain_ramp #(
   parameter int GAIN_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              fade_down,
   output logic [GAIN_W-1:0] gain
);

   localparam logic [GAIN_W-1:0] GAIN_TOP = {GAIN_W{1'b1}};

   logic [GAIN_W-1:0] gain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q <= GAIN_TOP;
      end else if (step_en) begin
         if (fade_down) begin
            if (gain_q != '0) gain_q <= gain_q - 1'b1;
         end else begin
            if (gain_q != GAIN_TOP) gain_q <= gain_q + 1'b1;
         end
      end
   end

   assign gain = gain_q;

endmodule

// File: rtl/pcm_gain_scale.sv
// Multiplies one signed sample by the unsigned gain, floor-scaled by 2^GAIN_W.
// Full-scale gain is treated as exact unity.
module pcm_gain_scale #(
   parameter int DATA_W = 24,
   parameter int GAIN_W = 10
) (
   input  logic [DATA_W-1:0] smp_in,
   input  logic [GAIN_W-1:0] gain,
   output logic [DATA_W-1:0] smp_out
);

   localparam int PROD_W = DATA_W + GAIN_W + 1;
   localparam logic [GAIN_W-1:0] GAIN_TOP = {GAIN_W{1'b1}};

   logic [PROD_W-1:0] smp_ext;
   logic [PROD_W-1:0] gain_ext;
   logic [PROD_W-1:0] prod;
   logic              sc_unused_bits;

   assign smp_ext  = {{(GAIN_W + 1){smp_in[DATA_W-1]}}, smp_in};
   assign gain_ext = {{(DATA_W + 1){1'b0}}, gain};
   assign prod     = $signed(smp_ext) * $signed(gain_ext);

   // Slicing above the fraction bits equals an arithmetic shift then truncate.
   assign sc_unused_bits = ^{prod[GAIN_W-1:0], prod[PROD_W-1]};

   always_comb begin
      if (gain == GAIN_TOP) smp_out = smp_in;
      else                  smp_out = prod[GAIN_W +: DATA_W];
   end

endmodule

// File: rtl/pcm_softmute.sv
module pcm_softmute
   import pcm_softmute_pkg::*;
#(
   parameter int DATA_W  = 24,
   parameter int GAIN_W  = 10,
   parameter int RUN_LEN = 1024,
   parameter int N_CH    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mute_mode,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_left,
   input  logic [DATA_W-1:0] in_right,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_left,
   output logic [DATA_W-1:0] out_right,
   output logic              automute
);

   // Elaboration-time parameter checks.
   if (DATA_W < 2) begin : g_bad_data_w
      $error("pcm_softmute: DATA_W must be at least 2");
   end
   if (GAIN_W < 2 || GAIN_W > 16) begin : g_bad_gain_w
      $error("pcm_softmute: GAIN_W must lie in 2..16");
   end
   if (RUN_LEN < 1) begin : g_bad_run
      $error("pcm_softmute: RUN_LEN must be positive");
   end
   if (N_CH != 2) begin : g_bad_ch
      $error("pcm_softmute: only a stereo pair is supported");
   end

   logic              zero_flag;
   logic              fade_down;
   logic              auto_sel;
   logic [GAIN_W-1:0] ramp_gain;
   logic [DATA_W-1:0] ch_in  [N_CH];
   logic [DATA_W-1:0] ch_out [N_CH];
   logic [DATA_W-1:0] ch_q   [N_CH];
   logic              valid_q;

   assign auto_sel  = mode_is_auto(mute_mode);
   assign fade_down = mode_forces_mute(mute_mode) || (auto_sel && zero_flag);

   assign ch_in[0] = in_left;
   assign ch_in[1] = in_right;

   pcm_zero_watch #(
      .DATA_W  (DATA_W),
      .RUN_LEN (RUN_LEN)
   ) zwatch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .watch_en  (auto_sel),
      .smp_valid (in_valid),
      .smp_left  (in_left),
      .smp_right (in_right),
      .run_flag  (zero_flag)
   );

   pcm_gain_ramp #(
      .GAIN_W (GAIN_W)
   ) ramp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (in_valid),
      .fade_down (fade_down),
      .gain      (ramp_gain)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      pcm_gain_scale #(
         .DATA_W (DATA_W),
         .GAIN_W (GAIN_W)
      ) scale_i (
         .smp_in  (ch_in[c]),
         .gain    (ramp_gain),
         .smp_out (ch_out[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ch_q[c] <= '0;
         else if (in_valid) ch_q[c] <= ch_out[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= in_valid;
   end

   assign out_valid = valid_q;
   assign out_left  = ch_q[0];
   assign out_right = ch_q[1];
   assign automute  = zero_flag;

endmodule

// File: rtl/pcm_softmute_chk.sv
module pcm_softmute_chk
   import pcm_softmute_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int GAIN_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mute_mode,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_left,
   input logic [DATA_W-1:0] in_right,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_left,
   input logic [DATA_W-1:0] out_right,
   input logic              automute,
   input logic [GAIN_W-1:0] ramp_gain
);

   localparam logic [GAIN_W-1:0] GTOP = {GAIN_W{1'b1}};

   AST_PASS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_mode == MUTE_MODE_PASS) |=> !automute); // R1

   AST_FORCED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_forces_mute(mute_mode) && in_valid) |=> (ramp_gain <= $past(ramp_gain))); // R2

   AST_FLAG_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(automute) |-> ($past(in_valid) && $past(in_left) == '0 && $past(in_right) == '0)); // R3

   AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_left != '0 || in_right != '0)) |=> !automute); // R4

   AST_GAIN_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(ramp_gain)); // R6

   AST_GAIN_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (ramp_gain == $past(ramp_gain) ||
                    ramp_gain == $past(ramp_gain) + 1'b1 ||
                    ramp_gain == $past(ramp_gain) - 1'b1)); // R6

   AST_ZERO_GAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ramp_gain == '0) |=> (out_left == '0 && out_right == '0)); // R7

   AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ramp_gain == GTOP) |=>
         (out_left == $past(in_left) && out_right == $past(in_right))); // R7

   AST_OUT_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right))); // R8

endmodule

bind pcm_softmute pcm_softmute_chk #(
   .DATA_W (DATA_W),
   .GAIN_W (GAIN_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .mute_mode (mute_mode),
   .in_valid  (in_valid),
   .in_left   (in_left),
   .in_right  (in_right),
   .out_valid (out_valid),
   .out_left  (out_left),
   .out_right (out_right),
   .automute  (automute),
   .ramp_gain (ramp_gain)
);

// File: tb/pcm_softmute_tb_top.sv
module pcm_softmute_tb_top;

   localparam int DW   = 24;
   localparam int GTOP = 1023;
   localparam int RUN  = 1024;
   localparam int NVEC = 12;

   // Each entry: {mode[1:0], left[23:0], right[23:0]}
   localparam logic [49:0] VEC [NVEC] = '{
      {2'b00, 24'h123456, 24'h654321},
      {2'b00, 24'h7FFFFF, 24'h800000},
      {2'b00, 24'hFFFFFF, 24'h000001},
      {2'b01, 24'h400000, 24'hC00000},
      {2'b01, 24'h7FFFFF, 24'h800000},
      {2'b01, 24'hFFFFFF, 24'h000400},
      {2'b11, 24'h0ABCDE, 24'hF54321},
      {2'b11, 24'h000000, 24'h7FFFFF},
      {2'b00, 24'h7FFFFF, 24'h800000},
      {2'b00, 24'h000555, 24'hFFFAAA},
      {2'b00, 24'h3FFFFF, 24'hC00001},
      {2'b00, 24'h123456, 24'h654321}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mute_mode = 2'b00;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_left = '0;
   logic [DW-1:0] in_right = '0;
   logic          out_valid;
   logic [DW-1:0] out_left;
   logic [DW-1:0] out_right;
   logic          automute;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   // Reference model state
   int m_gain = GTOP;
   int m_cnt  = 0;

   always #5 clk = ~clk;

   pcm_softmute dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mute_mode (mute_mode),
      .in_valid  (in_valid),
      .in_left   (in_left),
      .in_right  (in_right),
      .out_valid (out_valid),
      .out_left  (out_left),
      .out_right (out_right),
      .automute  (automute)
   );

   function automatic logic [DW-1:0] f_scale(input logic [DW-1:0] s, input int g);
      longint p;
      if (g == GTOP) return s;
      p = longint'($signed(s)) * longint'(g);
      return DW'(p >>> 10);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   // Drive one pair, check the registered result at the following negedge.
   task automatic send(input logic [1:0] md, input logic [DW-1:0] l,
                       input logic [DW-1:0] r, input string tag);
      logic [DW-1:0] el;
      logic [DW-1:0] er;
      bit pre_flag;
      bit down;
      @(negedge clk);
      mute_mode = md;
      in_left   = l;
      in_right  = r;
      in_valid  = 1'b1;
      el = f_scale(l, m_gain);
      er = f_scale(r, m_gain);
      pre_flag = (m_cnt == RUN);
      down = (md == 2'b01) || (md == 2'b11) || (md == 2'b10 && pre_flag);
      if (md != 2'b10)                 m_cnt = 0;
      else if (l != 0 || r != 0)       m_cnt = 0;
      else if (m_cnt != RUN)           m_cnt++;
      if (down && m_gain > 0)          m_gain--;
      else if (!down && m_gain < GTOP) m_gain++;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, {tag, " out_valid"}, 32'(out_valid), 32'd1);
      chk(out_left == el,  {tag, " out_left"},  32'(out_left),  32'(el));
      chk(out_right == er, {tag, " out_right"}, 32'(out_right), 32'(er));
      chk(automute == (m_cnt == RUN), {tag, " automute"}, 32'(automute),
          32'(m_cnt == RUN));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin : main
      logic [DW-1:0] hold_l;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(out_valid == 1'b0, "R10 out_valid", 32'(out_valid), 32'd0);
      chk(out_left == '0,    "R10 out_left",  32'(out_left),  32'd0);
      chk(out_right == '0,   "R10 out_right", 32'(out_right), 32'd0);
      chk(automute == 1'b0,  "R10 automute",  32'(automute),  32'd0);
      rst_n = 1'b1;

      // Table walk: unity pass, forced fade start, reserved code, recovery (R7)
      for (int i = 0; i < NVEC; i++) begin
         send(VEC[i][49:48], VEC[i][47:24], VEC[i][23:0], "R7 table");
      end

      // R8: output holds between samples
      hold_l = out_left;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R8 idle valid", 32'(out_valid), 32'd0);
      chk(out_left == hold_l, "R8 idle hold", 32'(out_left), 32'(hold_l));

      // R2: full forced fade reaches exact silence
      for (int i = 0; i < 1100; i++) send(2'b01, 24'h400000, 24'hC00000, "R2 fade");
      chk(out_left == '0,  "R2 silent left",  32'(out_left),  32'd0);
      chk(out_right == '0, "R2 silent right", 32'(out_right), 32'd0);

      // R1 / R6: ramp back to unity in pass mode
      for (int i = 0; i < 1100; i++) send(2'b00, 24'h400000, 24'hC00000, "R6 rise");
      chk(out_left == 24'h400000, "R1 unity left", 32'(out_left), 32'h400000);

      // R7: floor on a negative value at half gain (gain 512 after 511 steps)
      for (int i = 0; i < 511; i++) send(2'b01, 24'h000100, 24'hFFFF00, "R6 half");
      send(2'b01, 24'hFFFFFF, 24'h000003, "R7 floor");
      chk(out_left == 24'hFFFFFF, "R7 floor neg", 32'(out_left), 32'hFFFFFF);
      chk(out_right == 24'h000001, "R7 floor pos", 32'(out_right), 32'h1);
      for (int i = 0; i < 600; i++) send(2'b00, 24'h000010, 24'h000020, "R6 rise2");

      // R3: exact threshold of the zero run
      for (int i = 0; i < RUN - 1; i++) send(2'b10, '0, '0, "R3 run");
      chk(automute == 1'b0, "R3 before threshold", 32'(automute), 32'd0);
      send(2'b10, '0, '0, "R3 last");
      chk(automute == 1'b1, "R3 at threshold", 32'(automute), 32'd1);

      // R5: fading while flagged
      for (int i = 0; i < 10; i++) send(2'b10, '0, '0, "R5 fade");
      // R4: one non-zero channel clears the flag
      send(2'b10, 24'h000000, 24'h200000, "R4 clear");
      chk(automute == 1'b0, "R4 cleared", 32'(automute), 32'd0);
      for (int i = 0; i < 5; i++) send(2'b10, 24'h100000, 24'h100000, "R5 rise");

      // R9: mode change breaks the run
      for (int i = 0; i < RUN - 4; i++) send(2'b10, '0, '0, "R9 partial");
      send(2'b00, '0, '0, "R9 leave");
      for (int i = 0; i < 4; i++) send(2'b10, '0, '0, "R9 resume");
      chk(automute == 1'b0, "R9 no flag after break", 32'(automute), 32'd0);

      // R1: long zero run in pass mode never flags
      for (int i = 0; i < 1500; i++) send(2'b00, '0, '0, "R1 zeros");
      chk(automute == 1'b0, "R1 no flag in pass", 32'(automute), 32'd0);

      done = 1'b1;
      report();
   end

endmodule